// File: doc/BRIEF.md
# Floating-Point Status and Control Register

This block holds the 32-bit status and control word of a small floating-point unit. The CPU writes it through a single-cycle write port. Each write stores the value with every non-writable bit forced to zero, and it updates the rounding-mode field. From that field the block derives a one-hot rounding select that the arithmetic units consume. A rounding code the arithmetic units cannot perform leaves the current select in place and raises an error pulse.

The block also keeps a five-bit sticky exception accumulator. The arithmetic units set its bits through a strobed flag input. Every CPU write reloads the accumulator from the trap-enable field of the written word. The read port always shows the stored word with the live accumulator ORed into the low bits. A side port lets the comparator write the condition bit without going through the CPU.

Top module: `fp_status_ctrl`

## Requirements
- R1: A write stores `wr_data & 32'h2E00_1F00`. Stored bits outside that mask read as zero. Bits [4:0] of the read word come only from the accumulator.
- R2: The rounding field is bits [27:25]. After a write, the one-hot select `rnd_sel` on the next cycle is 4'b0001 for code 0 (nearest-even), 4'b0010 for code 1 (toward zero), 4'b0100 for code 2 (toward +infinity) and 4'b1000 for code 3 (toward -infinity).
- R3: Consider a write whose rounding code is 4 to 7 and differs from the stored code. On the next cycle it drives `rnd_unsup` high for exactly one cycle and leaves `rnd_sel` unchanged. The code itself is still stored and read back.
- R4: `rnd_sel` and `rnd_unsup` react only when the written rounding code differs from the stored one. Rewriting the same unsupported code raises no error.
- R5: The accumulator bits are bit 0 inexact, bit 1 underflow, bit 2 overflow, bit 3 divide-by-zero and bit 4 invalid. In a cycle without a write where `exc_vld` is high, `exc_set` is ORed into the accumulator. Set bits stay set, and `exc_set` has no effect while `exc_vld` is low.
- R6: Every write loads the accumulator from `wr_data[12:8]`. Bit order is the same as in R5. A flag strobe in the same cycle as a write is dropped.
- R7: `rd_data` equals the stored word ORed with the accumulator in bits [4:0].
- R8: In a cycle without a write, `cmp_vld` loads bit 29 with `cmp_cond` and leaves the other bits unchanged. A CPU write in the same cycle takes precedence.
- R9: A synchronous active-high reset clears the word, the accumulator and `rnd_unsup`, and selects nearest-even (`rnd_sel` = 4'b0001).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU write strobe |
| wr_data | input | 32 | CPU write value |
| rd_data | output | 32 | Stored word merged with the live sticky flags |
| exc_vld | input | 1 | Exception flag strobe from the arithmetic units |
| exc_set | input | 5 | Exception flags to accumulate |
| cmp_vld | input | 1 | Comparator condition update strobe |
| cmp_cond | input | 1 | Comparator condition result |
| rnd_sel | output | 4 | One-hot rounding select |
| rnd_unsup | output | 1 | Unsupported rounding code pulse |

## Verification
The bench builds the block with its default writable-bit mask. That puts every rounding code in reach: the four supported ones, the unimplemented ones and the two codes no encoding uses. It also reaches all five trap-enable bits and the condition bit. The vectors walk through changed and repeated rounding codes, including a repeated unsupported code. Directed cases cover flag accumulation while the strobe is held low, a flag strobe colliding with a write, and a comparator update colliding with a write.

// File: rtl/fpsc_pkg.sv
package fpsc_pkg;

    localparam int WORD_W    = 32;
    localparam int FLAG_W    = 5;
    localparam int RND_W     = 3;
    localparam int RND_LSB   = 25;
    localparam int TRAP_LSB  = 8;
    localparam int COND_BIT  = 29;
    localparam int RND_MODES = 4;

    localparam logic [WORD_W-1:0] WMASK_DEF = 32'h2E00_1F00;

    typedef enum logic [1:0] {
        RM_NEAREST = 2'd0,
        RM_ZERO    = 2'd1,
        RM_POS     = 2'd2,
        RM_NEG     = 2'd3
    } rnd_mode_e;

    typedef struct packed {
        logic      ok;
        rnd_mode_e mode;
    } rnd_dec_t;

    typedef struct packed {
        logic invalid;
        logic divzero;
        logic overflow;
        logic underflow;
        logic inexact;
    } exc_flags_t;

    function automatic rnd_dec_t decode_rnd(input logic [RND_W-1:0] code);
        rnd_dec_t d;
        d.ok   = 1'b1;
        d.mode = RM_NEAREST;
        case (code)
            3'd0:    d.mode = RM_NEAREST;
            3'd1:    d.mode = RM_ZERO;
            3'd2:    d.mode = RM_POS;
            3'd3:    d.mode = RM_NEG;
            default: d.ok   = 1'b0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/fpsc_word.sv
module fpsc_word
    import fpsc_pkg::*;
#(
    parameter logic [WORD_W-1:0] WRITE_MASK = WMASK_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              cmp_vld,
    input  logic              cmp_cond,
    output logic [WORD_W-1:0] word_q
);

    logic [WORD_W-1:0] word_d;

    always_comb begin
        word_d = word_q;
        if (wr_en) begin
            word_d = wr_data & WRITE_MASK;
        end else if (cmp_vld) begin
            word_d[COND_BIT] = cmp_cond & WRITE_MASK[COND_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else begin
            word_q <= word_d;
        end
    end

endmodule

// File: rtl/fpsc_sticky.sv
module fpsc_sticky
    import fpsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [FLAG_W-1:0] load_val,
    input  logic              exc_vld,
    input  logic [FLAG_W-1:0] exc_set,
    output logic [FLAG_W-1:0] acc_q
);

    for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                acc_q[i] <= 1'b0;
            end else if (wr_en) begin
                acc_q[i] <= load_val[i];
            end else if (exc_vld && exc_set[i]) begin
                acc_q[i] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/fpsc_rnd_ctrl.sv
module fpsc_rnd_ctrl
    import fpsc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [RND_W-1:0]     new_code,
    input  logic [RND_W-1:0]     old_code,
    output logic [RND_MODES-1:0] sel_q,
    output logic                 unsup_q
);

    rnd_dec_t             dec;
    logic                 changed;
    logic [RND_MODES-1:0] sel_d;

    assign dec     = decode_rnd(new_code);
    assign changed = wr_en && (new_code != old_code);

    for (genvar m = 0; m < RND_MODES; m++) begin : g_sel
        assign sel_d[m] = (int'(dec.mode) == m);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= RND_MODES'(1);
            unsup_q <= 1'b0;
        end else begin
            unsup_q <= changed && !dec.ok;
            if (changed && dec.ok) begin
                sel_q <= sel_d;
            end
        end
    end

endmodule

// File: rtl/fp_status_ctrl.sv
module fp_status_ctrl
    import fpsc_pkg::*;
#(
    parameter logic [31:0] WRITE_MASK = WMASK_DEF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    input  logic        exc_vld,
    input  logic [4:0]  exc_set,
    input  logic        cmp_vld,
    input  logic        cmp_cond,
    output logic [3:0]  rnd_sel,
    output logic        rnd_unsup
);

    logic [WORD_W-1:0] word_q;
    logic [FLAG_W-1:0] acc_q;
    exc_flags_t        flags;

    fpsc_word #(.WRITE_MASK(WRITE_MASK)) u_word (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .cmp_vld  (cmp_vld),
        .cmp_cond (cmp_cond),
        .word_q   (word_q)
    );

    fpsc_sticky u_sticky (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .load_val (wr_data[TRAP_LSB +: FLAG_W]),
        .exc_vld  (exc_vld),
        .exc_set  (exc_set),
        .acc_q    (acc_q)
    );

    fpsc_rnd_ctrl u_rnd (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .new_code (wr_data[RND_LSB +: RND_W]),
        .old_code (word_q[RND_LSB +: RND_W]),
        .sel_q    (rnd_sel),
        .unsup_q  (rnd_unsup)
    );

    assign flags   = exc_flags_t'(acc_q);
    assign rd_data = word_q | {{(WORD_W-FLAG_W){1'b0}}, flags};

endmodule

// File: rtl/fp_status_ctrl_chk.sv
module fp_status_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic [31:0] rd_data,
    input logic        exc_vld,
    input logic [4:0]  exc_set,
    input logic        cmp_vld,
    input logic [3:0]  rnd_sel,
    input logic        rnd_unsup
);

    assert_mask_R1: assert property (@(posedge clk) disable iff (rst)
        (rd_data & ~32'h2E00_1F1F) == 32'h0);

    assert_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $countones(rnd_sel) == 1);

    assert_unsup_keep_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[27:25] >= 3'd4 && wr_data[27:25] != rd_data[27:25])
        |=> (rnd_unsup && $stable(rnd_sel)));

    assert_same_code_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[27:25] == rd_data[27:25])
        |=> (!rnd_unsup && $stable(rnd_sel)));

    assert_sticky_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !exc_vld) |=> $stable(rd_data[4:0]));

    assert_write_load_R6: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_data[4:0] == $past(wr_data[12:8])));

    assert_cmp_keep_R8: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && cmp_vld && !exc_vld) |=> $stable(rd_data[28:0]));

endmodule

bind fp_status_ctrl fp_status_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .exc_vld   (exc_vld),
    .exc_set   (exc_set),
    .cmp_vld   (cmp_vld),
    .rnd_sel   (rnd_sel),
    .rnd_unsup (rnd_unsup)
);

// File: tb/fp_status_ctrl_bench.sv
module fp_status_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;

    localparam logic [31:0] VEC_WR [0:NVEC-1] = '{
        32'hFFFF_FFFF, 32'h0E00_0000, 32'h0200_0300, 32'h0400_0000, 32'h0600_1500,
        32'h0800_0000, 32'h0A00_0000, 32'h0000_0000, 32'h2000_0A00, 32'hD1FF_E0FF};
    localparam logic [31:0] VEC_RD [0:NVEC-1] = '{
        32'h2E00_1F1F, 32'h0E00_0000, 32'h0200_0303, 32'h0400_0000, 32'h0600_1515,
        32'h0800_0000, 32'h0A00_0000, 32'h0000_0000, 32'h2000_0A0A, 32'h0000_0000};
    localparam logic [3:0] VEC_RM [0:NVEC-1] = '{
        4'b0001, 4'b0001, 4'b0010, 4'b0100, 4'b1000,
        4'b1000, 4'b1000, 4'b0001, 4'b0001, 4'b0001};
    localparam logic VEC_ERR [0:NVEC-1] = '{
        1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        exc_vld = 1'b0;
    logic [4:0]  exc_set = '0;
    logic        cmp_vld = 1'b0;
    logic        cmp_cond = 1'b0;
    logic [3:0]  rnd_sel;
    logic        rnd_unsup;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fp_status_ctrl u_fp_status_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .exc_vld   (exc_vld),
        .exc_set   (exc_set),
        .cmp_vld   (cmp_vld),
        .cmp_cond  (cmp_cond),
        .rnd_sel   (rnd_sel),
        .rnd_unsup (rnd_unsup)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock edge; strobes are released 1 time unit after it, results read at 2.
    task automatic step();
        @(posedge clk);
        #1;
        wr_en   = 1'b0;
        exc_vld = 1'b0;
        cmp_vld = 1'b0;
        #1;
    endtask

    task automatic cpu_write(input logic [31:0] v);
        wr_en   = 1'b1;
        wr_data = v;
        step();
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        step();
        step();
        rst = 1'b0;
        // R9 reset state
        check("R9 rd_data", rd_data, 32'h0);
        check("R9 rnd_sel", {28'h0, rnd_sel}, 32'h1);
        check("R9 rnd_unsup", {31'h0, rnd_unsup}, 32'h0);

        // Vector walk: R1 mask, R2 mapping, R3/R4 unsupported and repeated codes, R6/R7
        for (int i = 0; i < NVEC; i++) begin
            cpu_write(VEC_WR[i]);
            check("R1/R6/R7 rd_data", rd_data, VEC_RD[i]);
            check("R2/R4 rnd_sel", {28'h0, rnd_sel}, {28'h0, VEC_RM[i]});
            check("R3/R4 rnd_unsup", {31'h0, rnd_unsup}, {31'h0, VEC_ERR[i]});
        end

        // R3: error is a single-cycle pulse
        cpu_write(32'h0800_0000);
        check("R3 pulse high", {31'h0, rnd_unsup}, 32'h1);
        step();
        check("R3 pulse low", {31'h0, rnd_unsup}, 32'h0);
        check("R3 code kept", rd_data, 32'h0800_0000);
        check("R3 sel kept", {28'h0, rnd_sel}, 32'h1);
        cpu_write(32'h0000_0000);

        // R5 sticky accumulation
        exc_vld = 1'b1; exc_set = 5'b00001;
        step();
        check("R5 inexact set", rd_data, 32'h1);
        exc_vld = 1'b1; exc_set = 5'b00100;
        step();
        check("R5 overflow ORed", rd_data, 32'h5);
        exc_set = 5'b11111;
        step();
        check("R5 no strobe ignored", rd_data, 32'h5);
        exc_set = 5'b00000;

        // R6 write wins over a same-cycle strobe
        exc_vld = 1'b1; exc_set = 5'b10000;
        cpu_write(32'h0000_0200);
        check("R6 write wins", rd_data, 32'h0000_0202);

        // R8 compare side port
        cmp_vld = 1'b1; cmp_cond = 1'b1;
        step();
        check("R8 cond set", rd_data, 32'h2000_0202);
        cmp_vld = 1'b1; cmp_cond = 1'b0;
        step();
        check("R8 cond clear", rd_data, 32'h0000_0202);
        cmp_vld = 1'b1; cmp_cond = 1'b1;
        cpu_write(32'h0000_0000);
        check("R8 write precedence", rd_data, 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule